// File: doc/BRIEF.md
# PS/2 Device-Side Host Byte Receiver

This block sits on the device end of a two-wire PS/2 link. It receives one byte that the host sends. The host first inhibits the bus by holding the clock line low. It then releases the clock while holding the data line low. When the block sees this, it takes over the clock. It produces a run of low and released clock phases and reads one bit near the end of each released phase. Once the frame is in, it checks the stop bit and the odd parity. It acknowledges the frame by pulling the data line low for one last clock.

When the stop bit is not high, the block does not give up at once. It keeps clocking until the host lets the data line go high, and then gives the acknowledge clock. A parameter caps how many of these extra clocks it will produce. After the cap it simply releases the bus.

The result is reported by one-cycle strobes: a valid byte, a parity error or a framing error. Logic above this block turns either error into a Resend request. `busy` covers the whole clocked exchange, so the transmit path can keep out of the way. Both line outputs are drive-low enables for open-drain pads.

Top module: `ps2_host_rx`

## Requirements
- R1: While `busy` is low, neither line is driven. A receive starts only after the clock line has been low for at least INHIBIT_CYC system clocks and then reads high while the data line reads low.
- R2: During a receive, each generated clock pulls the clock line low for HALF_CYC system clocks and then releases it for HALF_CYC system clocks. `busy` stays high from the first clock to the end of the last one.
- R3: The data line is sampled in the last system clock of each released phase. Generated clocks 1 to 8 carry data bits 0 to 7, least significant bit first. Clock 9 carries the parity bit and clock 10 carries the stop bit.
- R4: If the stop bit reads high, the data line is driven low during both phases of an 11th clock and is then released. A correct frame therefore uses exactly 11 clocks.
- R5: Parity is odd over the eight data bits and the parity bit. When parity is correct and the stop bit is high, `rx_valid` pulses for one cycle and `rx_byte` holds the byte.
- R6: A parity mismatch with a good stop bit gives a one-cycle `parity_err` pulse, no `rx_valid`, and the normal acknowledge clock.
- R7: If the stop bit reads low, extra clocks follow until a sample reads high, and then the acknowledge clock is given. Holding the data line low through k extra falling edges gives 12+k clocks in total. This is followed by a `frame_err` pulse and no `rx_valid`.
- R8: If the data line is still low after MAX_EXTRA extra clocks, the block releases the bus with no acknowledge clock. It pulses `frame_err`, and the total is 10+MAX_EXTRA clocks.
- R9: The result strobes are issued in the same cycle that `busy` falls, and at most one of them is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ps2_clk_in | input | 1 | Synchronised level of the PS/2 clock line |
| ps2_data_in | input | 1 | Synchronised level of the PS/2 data line |
| ps2_clk_drive_low | output | 1 | Pull the clock line low |
| ps2_data_drive_low | output | 1 | Pull the data line low |
| busy | output | 1 | Receive exchange in progress |
| rx_byte | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe: byte received correctly |
| parity_err | output | 1 | One-cycle strobe: parity mismatch |
| frame_err | output | 1 | One-cycle strobe: stop bit low |

## Verification
Some properties are checked on every cycle. The lines stay undriven while the block is idle. A receive begins only from the request-to-send line state. The acknowledge drive starts within a clock low phase. The strobes are mutually exclusive, last a single cycle and coincide with the end of `busy`.

Other behaviour can only be shown by the bench's host model, which counts clock falls and watches the data line. This covers the byte value, the exact number of clocks for good, bad-parity, late-stop and abandoned frames, and whether an acknowledge was seen. The same applies to the refusal to start after too short an inhibit.

// File: rtl/ps2_host_rx.sv
module ps2_host_rx #(
  parameter int HALF_CYC    = 2000,
  parameter int INHIBIT_CYC = 5000,
  parameter int MAX_EXTRA   = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ps2_clk_in,
  input  logic       ps2_data_in,
  output logic       ps2_clk_drive_low,
  output logic       ps2_data_drive_low,
  output logic       busy,
  output logic [7:0] rx_byte,
  output logic       rx_valid,
  output logic       parity_err,
  output logic       frame_err
);
  localparam int TW = $clog2(HALF_CYC + 1);
  localparam int IW = $clog2(INHIBIT_CYC + 1);
  localparam int XW = $clog2(MAX_EXTRA + 1);

  typedef enum logic [2:0] {S_IDLE, S_LOW, S_HIGH, S_ACK_LOW, S_ACK_HIGH} st_t;
  st_t st;

  logic [TW-1:0] tmr;
  logic [IW-1:0] inh;
  logic [XW-1:0] extra;
  logic [3:0]    bitn;
  logic [7:0]    sr;
  logic          par, framed;

  wire armed   = (inh == IW'(INHIBIT_CYC));
  wire tdone   = (tmr == '0);
  wire par_ok  = ^{sr, par};

  assign busy               = (st != S_IDLE);
  assign ps2_clk_drive_low  = (st == S_LOW) || (st == S_ACK_LOW);
  assign ps2_data_drive_low = (st == S_ACK_LOW) || (st == S_ACK_HIGH);
  assign rx_byte            = sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; tmr <= '0; inh <= '0; extra <= '0; bitn <= '0;
      sr <= '0; par <= 1'b0; framed <= 1'b0;
      rx_valid <= 1'b0; parity_err <= 1'b0; frame_err <= 1'b0;
    end else begin
      rx_valid <= 1'b0; parity_err <= 1'b0; frame_err <= 1'b0;
      if (!tdone) tmr <= tmr - 1'b1;
      case (st)
        S_IDLE: begin
          if (!ps2_clk_in) begin
            if (!armed) inh <= inh + 1'b1;
          end else begin
            inh <= '0;
            if (armed && !ps2_data_in) begin
              st <= S_LOW; tmr <= TW'(HALF_CYC - 1);
              bitn <= '0; extra <= '0; framed <= 1'b0;
            end
          end
        end
        S_LOW: if (tdone) begin
          st <= S_HIGH; tmr <= TW'(HALF_CYC - 1);
          if (bitn != 4'd11) bitn <= bitn + 1'b1;
        end
        S_HIGH: if (tdone) begin
          tmr <= TW'(HALF_CYC - 1);
          st  <= S_LOW;
          if (bitn <= 4'd8) sr <= {ps2_data_in, sr[7:1]};
          else if (bitn == 4'd9) par <= ps2_data_in;
          else if (ps2_data_in) st <= S_ACK_LOW;
          else if (bitn == 4'd10) framed <= 1'b1;
          else if (extra == XW'(MAX_EXTRA - 1)) begin
            st <= S_IDLE; frame_err <= 1'b1;
          end else extra <= extra + 1'b1;
        end
        S_ACK_LOW: if (tdone) begin
          st <= S_ACK_HIGH; tmr <= TW'(HALF_CYC - 1);
        end
        S_ACK_HIGH: if (tdone) begin
          st <= S_IDLE;
          frame_err  <= framed;
          parity_err <= !framed && !par_ok;
          rx_valid   <= !framed && par_ok;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module ps2_host_rx_chk (
  input logic clk,
  input logic rst_n,
  input logic ps2_clk_in,
  input logic ps2_data_in,
  input logic ps2_clk_drive_low,
  input logic ps2_data_drive_low,
  input logic busy,
  input logic rx_valid,
  input logic parity_err,
  input logic frame_err
);
  a_r1_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!ps2_clk_drive_low && !ps2_data_drive_low));
  a_r1_start_on_rts: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(ps2_clk_in) && !$past(ps2_data_in)));
  a_r4_ack_starts_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ps2_data_drive_low) |-> ps2_clk_drive_low);
  a_r9_strobe_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid || parity_err || frame_err) |-> $fell(busy));
  a_r9_one_result: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rx_valid, parity_err, frame_err}));
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
endmodule

bind ps2_host_rx ps2_host_rx_chk i_chk (.*);

// File: tb/test_ps2_host_rx.sv
module test_ps2_host_rx;
  localparam int HALF = 4, INH = 20, MAXX = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic host_clk_low = 1'b0, host_data_low = 1'b0;
  logic dev_clk_low, dev_data_low, busy, rx_valid, parity_err, frame_err;
  logic [7:0] rx_byte;
  wire clk_line  = !(host_clk_low || dev_clk_low);
  wire data_line = !(host_data_low || dev_data_low);

  always #2.5 clk = ~clk;

  ps2_host_rx #(.HALF_CYC(HALF), .INHIBIT_CYC(INH), .MAX_EXTRA(MAXX)) i_ps2_host_rx (
    .clk(clk), .rst_n(rst_n), .ps2_clk_in(clk_line), .ps2_data_in(data_line),
    .ps2_clk_drive_low(dev_clk_low), .ps2_data_drive_low(dev_data_low),
    .busy(busy), .rx_byte(rx_byte), .rx_valid(rx_valid),
    .parity_err(parity_err), .frame_err(frame_err));

  int checks = 0, fails = 0, cycles = 0;
  int falls = 0, n_valid = 0, n_perr = 0, n_ferr = 0;
  bit ack_seen = 0;
  logic [7:0] got_byte = '0;

  always @(negedge clk_line) falls++;
  always @(negedge clk) begin
    cycles++;
    if (rx_valid) begin n_valid++; got_byte = rx_byte; end
    if (parity_err) n_perr++;
    if (frame_err) n_ferr++;
    if (busy && !data_line && !host_data_low) ack_seen = 1;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles, expected < 100000", cycles);
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    falls = 0; n_valid = 0; n_perr = 0; n_ferr = 0; ack_seen = 0;
  endtask

  task automatic send(input logic [7:0] b, input bit flip_par, input bit stop_hi,
                      input int hold, input bit never_release);
    logic [10:1] bits;
    bits[8:1] = b; bits[9] = ~^b ^ flip_par; bits[10] = stop_hi;
    host_clk_low = 1;
    repeat (INH + 2) @(negedge clk);
    host_data_low = 1;
    @(negedge clk);
    clear_mon();
    host_clk_low = 0;
    for (int i = 1; i <= 10; i++) begin
      @(negedge clk_line); #1;
      host_data_low = !bits[i];
    end
    if (!stop_hi) begin
      if (never_release) begin
        while (busy) @(negedge clk);
      end else begin
        repeat (hold) @(negedge clk_line);
        @(negedge clk_line); #1;
      end
      host_data_low = 0;
    end
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 reset busy", busy, 0);
    chk("R1 reset clk drive", dev_clk_low, 0);
    chk("R1 reset data drive", dev_data_low, 0);
    chk("R9 reset strobes", {rx_valid, parity_err, frame_err}, 0);
  endtask

  task automatic t_good(input logic [7:0] b);
    send(b, 0, 1, 0, 0);
    chk("R5 valid count", n_valid, 1);
    chk("R3 byte value", got_byte, b);
    chk("R4 clock count", falls, 11);
    chk("R4 ack seen", ack_seen, 1);
    chk("R6 no parity err", n_perr, 0);
  endtask

  task automatic t_parity();
    send(8'h3C, 1, 1, 0, 0);
    chk("R6 parity err count", n_perr, 1);
    chk("R6 no valid", n_valid, 0);
    chk("R6 ack seen", ack_seen, 1);
    chk("R2 clock count", falls, 11);
  endtask

  task automatic t_frame();
    send(8'h5A, 0, 0, 2, 0);
    chk("R7 frame err count", n_ferr, 1);
    chk("R7 no valid", n_valid, 0);
    chk("R7 clock count", falls, 14);
    chk("R7 ack seen", ack_seen, 1);
  endtask

  task automatic t_giveup();
    send(8'h81, 0, 0, 0, 1);
    chk("R8 frame err count", n_ferr, 1);
    chk("R8 clock count", falls, 10 + MAXX);
    chk("R8 no ack", ack_seen, 0);
    chk("R8 busy released", busy, 0);
  endtask

  task automatic t_short_inhibit();
    int busy_seen = 0;
    host_clk_low = 1;
    repeat (INH / 4) @(negedge clk);
    host_data_low = 1;
    @(negedge clk);
    clear_mon();
    host_clk_low = 0;
    repeat (6 * HALF) begin @(negedge clk); if (busy) busy_seen = 1; end
    chk("R1 short inhibit no start", busy_seen, 0);
    chk("R1 short inhibit no clocks", falls, 0);
    host_data_low = 0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_good(8'hA5);
    t_good(8'h00);
    t_good(8'hFF);
    t_parity();
    t_frame();
    t_giveup();
    t_short_inhibit();
    t_good(8'h12);
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule